// File: doc/BRIEF.md
# Credit-Gated Static-Priority Arbiter

This block decides which of N requestors may use a shared resource, such as a memory, for the next fixed-size service unit. Each time the resource finishes one unit, it pulses a slot strobe. On that strobe the arbiter picks one requestor and announces it on a one-hot grant with a valid flag. A requestor can win only when it has a request pending and has built up enough credit. Among the requestors that qualify, the one with the lowest index wins.

Each requestor holds a credit counter. On every slot the counter grows by a programmed numerator and saturates at a programmed ceiling. A grant costs a programmed denominator. The numerator/denominator ratio sets the share of bandwidth the requestor is allowed. The ceiling sets how many back-to-back units it may take after a quiet period. Because bandwidth comes from the ratio and latency comes from the index, the two are set independently. A low-index requestor gets short waits, yet it cannot take more than its budget, so higher-index requestors still make progress. The rates are programmed through a small register-style write port.

Top module: `cr_sp_arbiter`

## Requirements
- R1: After reset, grant and valid are low and every credit counter is zero. Every numerator is 0, every denominator is 1 and every ceiling is 0, so no grant is issued until the registers are programmed.
- R2: Grant and valid change only in the clock cycle after a cycle in which `slot_i` is high, and they stay valid for one cycle. In every other cycle both are zero.
- R3: While valid is high, exactly one bit of `gnt_o` is set. While valid is low, `gnt_o` is zero.
- R4: A requestor is eligible in a slot when its `req_i` bit is high and its credit is at least its denominator.
- R5: When at least one requestor is eligible, the grant goes to the eligible requestor with the lowest index (index 0 has the highest priority).
- R6: On every slot, the credit becomes min(credit − cost + numerator, ceiling). The cost is the denominator if the requestor was granted in that slot, and zero otherwise.
- R7: If no requestor is eligible in a slot, valid stays low and no credit is charged.
- R8: A denominator of 0 makes a requestor eligible whenever its request is pending, and a grant then costs nothing.
- R9: A write with `cfg_we_i` high stores `cfg_data_i` into the requestor chosen by `cfg_idx_i`. Field code 0 is the numerator, 1 the denominator and 2 the ceiling. Code 3 is ignored. The new value is used from the next slot after the write edge.
- R10: A granted requestor always had its `req_i` bit high in the slot cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| slot_i | input | 1 | Service-unit done strobe; one scheduling decision per high cycle |
| req_i | input | N_REQ | Pending-request flag per requestor |
| cfg_we_i | input | 1 | Configuration write enable |
| cfg_idx_i | input | IDX_W | Requestor addressed by the write |
| cfg_fld_i | input | 2 | Field code: 0 numerator, 1 denominator, 2 ceiling, 3 ignored |
| cfg_data_i | input | CRED_W | Value written |
| gnt_o | output | N_REQ | One-hot grant, valid for one cycle |
| gnt_vld_o | output | 1 | Grant valid |

## Verification
The bench builds the block with four requestors and 8-bit credits. This is enough to give each priority level a different rate, to include one requestor with a zero denominator, and to make ceilings small enough that saturation appears within a few idle slots. The stimulus includes back-to-back slots and slots separated by idle cycles. It uses full and sparse request patterns, a ceiling lowered below the credit a requestor has already built up, and a write with the ignored field code. With these, every eligibility rule and every clamp is reached within a few hundred cycles.

// File: rtl/cr_arb_pkg.sv
package cr_arb_pkg;

  localparam int CFG_FLD_W = 2;

  typedef enum logic [CFG_FLD_W-1:0] {
    FLD_NUM  = 2'd0,
    FLD_DEN  = 2'd1,
    FLD_CEIL = 2'd2,
    FLD_RSVD = 2'd3
  } cfg_fld_e;

endpackage

// File: rtl/cr_rst_sync.sv
module cr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];

endmodule

// File: rtl/cr_cfg_regs.sv
module cr_cfg_regs
  import cr_arb_pkg::*;
#(
  parameter int N_REQ  = 4,
  parameter int CRED_W = 8,
  parameter int IDX_W  = 2
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           we_i,
  input  logic [IDX_W-1:0]               idx_i,
  input  logic [CFG_FLD_W-1:0]           fld_i,
  input  logic [CRED_W-1:0]              data_i,
  output logic [N_REQ-1:0][CRED_W-1:0]   num_o,
  output logic [N_REQ-1:0][CRED_W-1:0]   den_o,
  output logic [N_REQ-1:0][CRED_W-1:0]   ceil_o
);

  localparam logic [CRED_W-1:0] DEN_RST = CRED_W'(1);

  cfg_fld_e fld;
  assign fld = cfg_fld_e'(fld_i);

  for (genvar g = 0; g < N_REQ; g++) begin : g_req
    localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(g);

    logic              hit;
    logic              num_en, den_en, ceil_en;
    logic [CRED_W-1:0] num_q, den_q, ceil_q;

    always_comb begin
      hit     = we_i && (idx_i == MY_IDX);
      num_en  = hit && (fld == FLD_NUM);
      den_en  = hit && (fld == FLD_DEN);
      ceil_en = hit && (fld == FLD_CEIL);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        num_q  <= '0;
        den_q  <= DEN_RST;
        ceil_q <= '0;
      end else begin
        if (num_en)  num_q  <= data_i;
        if (den_en)  den_q  <= data_i;
        if (ceil_en) ceil_q <= data_i;
      end
    end

    assign num_o[g]  = num_q;
    assign den_o[g]  = den_q;
    assign ceil_o[g] = ceil_q;
  end

endmodule

// File: rtl/cr_credit_unit.sv
module cr_credit_unit #(
  parameter int CRED_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slot_i,
  input  logic              req_i,
  input  logic              win_i,
  input  logic [CRED_W-1:0] num_i,
  input  logic [CRED_W-1:0] den_i,
  input  logic [CRED_W-1:0] ceil_i,
  output logic              elig_o
);

  logic [CRED_W-1:0] credit_q;
  logic [CRED_W-1:0] credit_d;
  logic [CRED_W-1:0] cost;
  logic [CRED_W-1:0] after_use;
  logic [CRED_W:0]   grown;

  always_comb begin
    elig_o    = req_i && (credit_q >= den_i);
    cost      = win_i ? den_i : '0;
    after_use = credit_q - cost;
    grown     = {1'b0, after_use} + {1'b0, num_i};
    if (grown > {1'b0, ceil_i}) credit_d = ceil_i;
    else                        credit_d = grown[CRED_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      credit_q <= '0;
    else if (slot_i) credit_q <= credit_d;
  end

endmodule

// File: rtl/cr_prio_pick.sv
module cr_prio_pick #(
  parameter int N_REQ = 4
) (
  input  logic [N_REQ-1:0] elig_i,
  output logic [N_REQ-1:0] pick_o,
  output logic             any_o
);

  logic [N_REQ:0] blocked;

  always_comb begin
    blocked[0] = 1'b0;
    for (int k = 0; k < N_REQ; k++) begin
      pick_o[k]     = elig_i[k] && !blocked[k];
      blocked[k+1]  = blocked[k] || elig_i[k];
    end
    any_o = blocked[N_REQ];
  end

endmodule

// File: rtl/cr_sp_arbiter.sv
module cr_sp_arbiter #(
  parameter int N_REQ  = 4,
  parameter int CRED_W = 8,
  parameter int IDX_W  = (N_REQ > 1) ? $clog2(N_REQ) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slot_i,
  input  logic [N_REQ-1:0]  req_i,
  input  logic              cfg_we_i,
  input  logic [IDX_W-1:0]  cfg_idx_i,
  input  logic [1:0]        cfg_fld_i,
  input  logic [CRED_W-1:0] cfg_data_i,
  output logic [N_REQ-1:0]  gnt_o,
  output logic              gnt_vld_o
);

  logic                         rst_sync_n;
  logic [N_REQ-1:0][CRED_W-1:0] num_w, den_w, ceil_w;
  logic [N_REQ-1:0]             elig_w;
  logic [N_REQ-1:0]             pick_w;
  logic                         any_w;
  logic [N_REQ-1:0]             win_w;
  logic [N_REQ-1:0]             gnt_q, gnt_d;
  logic                         vld_q, vld_d;

  cr_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  cr_cfg_regs #(
    .N_REQ  (N_REQ),
    .CRED_W (CRED_W),
    .IDX_W  (IDX_W)
  ) u_cfg (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .we_i   (cfg_we_i),
    .idx_i  (cfg_idx_i),
    .fld_i  (cfg_fld_i),
    .data_i (cfg_data_i),
    .num_o  (num_w),
    .den_o  (den_w),
    .ceil_o (ceil_w)
  );

  for (genvar g = 0; g < N_REQ; g++) begin : g_cred
    cr_credit_unit #(.CRED_W(CRED_W)) u_unit (
      .clk    (clk),
      .rst_n  (rst_sync_n),
      .slot_i (slot_i),
      .req_i  (req_i[g]),
      .win_i  (win_w[g]),
      .num_i  (num_w[g]),
      .den_i  (den_w[g]),
      .ceil_i (ceil_w[g]),
      .elig_o (elig_w[g])
    );
  end

  cr_prio_pick #(.N_REQ(N_REQ)) u_pick (
    .elig_i (elig_w),
    .pick_o (pick_w),
    .any_o  (any_w)
  );

  always_comb begin
    win_w = pick_w & {N_REQ{slot_i}};
    gnt_d = win_w;
    vld_d = slot_i && any_w;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      gnt_q <= '0;
      vld_q <= 1'b0;
    end else begin
      gnt_q <= gnt_d;
      vld_q <= vld_d;
    end
  end

  assign gnt_o     = gnt_q;
  assign gnt_vld_o = vld_q;

endmodule

// File: rtl/cr_sp_arbiter_chk.sv
module cr_sp_arbiter_chk #(
  parameter int N_REQ = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             slot_i,
  input logic [N_REQ-1:0] req_i,
  input logic [N_REQ-1:0] elig,
  input logic [N_REQ-1:0] gnt_o,
  input logic             gnt_vld_o
);

  // R3
  a_r3_one_hot: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_vld_o |-> ($countones(gnt_o) == 1));

  // R3
  a_r3_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !gnt_vld_o |-> (gnt_o == '0));

  // R2
  a_r2_after_slot: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_vld_o |-> $past(slot_i));

  // R10
  a_r10_had_req: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_vld_o |-> ((gnt_o & $past(req_i)) != '0));

  // R4
  a_r4_was_elig: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_vld_o |-> ((gnt_o & $past(elig)) != '0));

  // R5
  a_r5_lowest_idx: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_vld_o |-> (((gnt_o - 1'b1) & $past(elig)) == '0));

  // R7
  a_r7_grant_if_any: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_i && (elig != '0)) |=> gnt_vld_o);

endmodule

bind cr_sp_arbiter cr_sp_arbiter_chk #(.N_REQ(N_REQ)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .slot_i    (slot_i),
  .req_i     (req_i),
  .elig      (elig_w),
  .gnt_o     (gnt_o),
  .gnt_vld_o (gnt_vld_o)
);

// File: tb/tb_cr_sp_arbiter.sv
module tb_cr_sp_arbiter;

  localparam int N  = 4;
  localparam int W  = 8;
  localparam int IW = 2;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          slot_i;
  logic [N-1:0]  req_i;
  logic          cfg_we_i;
  logic [IW-1:0] cfg_idx_i;
  logic [1:0]    cfg_fld_i;
  logic [W-1:0]  cfg_data_i;
  logic [N-1:0]  gnt_o;
  logic          gnt_vld_o;

  always #5 clk = ~clk;

  cr_sp_arbiter #(.N_REQ(N), .CRED_W(W)) dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .slot_i     (slot_i),
    .req_i      (req_i),
    .cfg_we_i   (cfg_we_i),
    .cfg_idx_i  (cfg_idx_i),
    .cfg_fld_i  (cfg_fld_i),
    .cfg_data_i (cfg_data_i),
    .gnt_o      (gnt_o),
    .gnt_vld_o  (gnt_vld_o)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  bit mon_on = 0;
  logic slot_q = 1'b0;

  int m_num[N], m_den[N], m_ceil[N], m_cr[N];

  typedef struct {
    logic [N-1:0] gnt;
    logic         vld;
    string        tag;
  } exp_t;
  exp_t sb[$];

  task automatic check(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // R9: field 0 numerator, 1 denominator, 2 ceiling, 3 ignored
  task automatic cfg_write(int idx, int fld, int val);
    cfg_we_i   = 1'b1;
    cfg_idx_i  = IW'(idx);
    cfg_fld_i  = 2'(fld);
    cfg_data_i = W'(val);
    case (fld)
      0: m_num[idx]  = val;
      1: m_den[idx]  = val;
      2: m_ceil[idx] = val;
      default: ;
    endcase
    @(negedge clk);
    cfg_we_i = 1'b0;
  endtask

  task automatic do_slot(logic [N-1:0] r, string tag);
    exp_t e;
    int   win;
    int   v;
    win = -1;
    for (int k = 0; k < N; k++)                     // R4, R5
      if (win < 0 && r[k] && m_cr[k] >= m_den[k]) win = k;
    e.gnt = '0;
    e.vld = (win >= 0);
    if (win >= 0) e.gnt[win] = 1'b1;
    e.tag = tag;
    sb.push_back(e);
    for (int k = 0; k < N; k++) begin               // R6, R8
      v = m_cr[k] - ((k == win) ? m_den[k] : 0) + m_num[k];
      m_cr[k] = (v > m_ceil[k]) ? m_ceil[k] : v;
    end
    req_i  = r;
    slot_i = 1'b1;
    @(negedge clk);
    slot_i = 1'b0;
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  always @(posedge clk) slot_q <= slot_i;

  // monitor
  always @(negedge clk) begin
    if (mon_on) begin
      if (slot_q) begin
        if (sb.size() == 0) begin
          check(0, "R2", "unexpected result slot", 1, 0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          check(gnt_vld_o == e.vld, e.tag, "valid", int'(gnt_vld_o), int'(e.vld));
          check(gnt_o == e.gnt, e.tag, "grant", int'(gnt_o), int'(e.gnt));
        end
      end else begin
        check(!gnt_vld_o && gnt_o == '0, "R2", "quiet cycle grant",
              int'({gnt_vld_o, gnt_o}), 0);
      end
    end
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < N; k++) begin
      m_num[k] = 0; m_den[k] = 1; m_ceil[k] = 0; m_cr[k] = 0;
    end
    rst_n = 1'b0; slot_i = 1'b0; req_i = '0;
    cfg_we_i = 1'b0; cfg_idx_i = '0; cfg_fld_i = '0; cfg_data_i = '0;
    repeat (3) @(negedge clk);
    check(gnt_o == '0 && !gnt_vld_o, "R1", "outputs in reset", int'({gnt_vld_o, gnt_o}), 0);
    rst_n = 1'b1;
    idle(4);
    check(gnt_o == '0 && !gnt_vld_o, "R1", "outputs after reset", int'({gnt_vld_o, gnt_o}), 0);
    mon_on = 1'b1;

    // R1, R7: unprogrammed, nobody qualifies
    for (int i = 0; i < 3; i++) do_slot(4'hF, "R1");
    idle(2);

    // program budgets
    cfg_write(0, 0, 1); cfg_write(0, 1, 4); cfg_write(0, 2, 8);
    cfg_write(1, 0, 2); cfg_write(1, 1, 4); cfg_write(1, 2, 8);
    cfg_write(2, 0, 3); cfg_write(2, 1, 2); cfg_write(2, 2, 6);
    cfg_write(3, 0, 1); cfg_write(3, 1, 0); cfg_write(3, 2, 3);
    idle(1);

    // R5: all requesting, back-to-back slots
    for (int i = 0; i < 30; i++) do_slot(4'hF, "R5");
    idle(3);

    // R4, R10: sparse patterns with gaps
    for (int i = 0; i < 40; i++) begin
      do_slot(N'((i * 7 + 1) & 15), "R4");
      if (i % 5 == 4) idle(2);
    end
    idle(2);

    // R6: saturation then drain for requestor 2
    cfg_write(2, 0, 1); cfg_write(2, 1, 2); cfg_write(2, 2, 5);
    for (int i = 0; i < 12; i++) do_slot(4'h0, "R7");
    for (int i = 0; i < 10; i++) do_slot(4'b0100, "R6");
    idle(2);

    // R9: lowered ceiling and an ignored field write
    for (int i = 0; i < 6; i++) do_slot(4'h0, "R6");
    cfg_write(1, 2, 1);
    cfg_write(0, 3, 0);
    idle(1);
    for (int i = 0; i < 8; i++) do_slot(4'b0011, "R9");
    idle(2);

    // R8: zero denominator
    for (int i = 0; i < 6; i++) do_slot(4'b1000, "R8");
    for (int i = 0; i < 10; i++) do_slot(4'b1001, "R8");
    idle(3);

    check(sb.size() == 0, "R2", "results outstanding", sb.size(), 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule